// File: doc/BRIEF.md
# Context-Tagged Translation Lookup with Access Check

This block is a small fully associative translation buffer for a memory management unit that maps 32-bit virtual addresses onto a 36-bit physical space. A processor core uses two copies of it: one on the instruction fetch path and one on the data path. Each lookup request carries a virtual address, an access kind (read, write or execute) and a supervisor flag. The block compares the request, together with the current 8-bit context, against every entry in parallel. Each entry sets its own page size (4 kB, 256 kB, 16 MB or 4 GB), so each entry compares a different number of tag bits. The response reports one of four outcomes: a translated address with its cacheable flag, a miss, a protection fault, or a request to mark the page modified before the write may go ahead.

Requests use a valid/ready handshake, and responses leave through a one-deep registered valid/ready stage. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the response register is empty or is being drained in the same cycle. While a response is held with `rsp_ready` low, the block takes no new request and its response does not change. A separate plain write port lets the refill logic load one entry per cycle or clear every entry at once. Table walking, the choice of victim and trap delivery belong to the surrounding unit.

Top module: `tlbx_lookup`

## Requirements
- R1: After reset `rsp_valid` is low and every entry is invalid, so the first enabled lookup returns a miss.
- R2: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` equals `!rsp_valid || rsp_ready`. The response for an accepted request appears in the next cycle. A response that is valid while `rsp_ready` is low stays valid and unchanged.
- R3: With `xlate_en` low, the result code is 0 and `rsp_paddr` is the virtual address zero-extended to 36 bits, with `rsp_cacheable` low, whatever the table holds.
- R4: A valid entry matches only if its tag equals the virtual address on the bits its size code selects. Code 0 compares bits 31..12, code 1 compares bits 31..18, code 2 compares bits 31..24, and code 3 compares no address bits.
- R5: On a permitted hit the result code is 0. The physical address takes the entry's page number above the page offset and the virtual address bits within the page offset. `rsp_cacheable` is the entry's cacheable bit.
- R6: An entry whose context differs from `cur_ctx` does not match, unless its access code is 6 or 7. Entries with those codes match in every context.
- R7: On a hit that the access code forbids, the result code is 2. Access kind 0 is a read, 1 is a write, 2 is an execute, and 3 is checked as a read. The rights per code, written user/supervisor, are: 0 read/read; 1 read-write/read-write; 2 read-execute/read-execute; 3 all/all; 4 execute/execute; 5 read/read-write; 6 none/read-execute; 7 none/all.
- R8: A permitted write that hits an entry whose modified bit is clear gives result code 3 and no translation. A forbidden write gives code 2 even when the page is clean.
- R9: When no entry matches with translation enabled, the result code is 1. For every result code other than 0, `rsp_paddr` and `rsp_cacheable` are zero.
- R10: When several entries match, the entry with the lowest index decides the result.
- R11: With `wr_en` high, the entry at `wr_idx` takes the written fields at the clock edge. A lookup accepted in the same cycle still sees the old contents, and requests accepted afterwards see the new contents.
- R12: `inv_all` clears the valid bit of every entry at the clock edge. It takes precedence over a write in the same cycle, so nothing is loaded in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xlate_en | input | 1 | Translation enable; low gives identity mapping |
| cur_ctx | input | 8 | Current context number |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 read |
| req_super | input | 1 | Request made in supervisor mode |
| rsp_valid | output | 1 | Response held |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_code | output | 2 | 0 translated, 1 miss, 2 protection fault, 3 modified-bit update needed |
| rsp_paddr | output | 36 | Physical address (zero unless code 0) |
| rsp_cacheable | output | 1 | Cacheable flag of the hit page |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | 2 | Index of the entry to load |
| wr_valid | input | 1 | Valid bit to store |
| wr_vtag | input | 20 | Virtual tag, address bits 31..12 |
| wr_psize | input | 2 | Page size code |
| wr_ctx | input | 8 | Context tag |
| wr_acc | input | 3 | Access permission code |
| wr_ppn | input | 24 | Physical page number, address bits 35..12 |
| wr_cacheable | input | 1 | Cacheable bit to store |
| wr_modified | input | 1 | Modified bit to store |
| inv_all | input | 1 | Clear every valid bit |

## Verification
The bench targets pages larger than 4 kB. A matcher with a fixed compare width would miss addresses in the upper part of a 256 kB or 16 MB page, or would splice the wrong bits into the physical address. It checks supervisor-only entries from a foreign context: a design that always compares the context misses there, and one that skips the user-mode fault hands user code a kernel page. It checks overlapping entries and a write to a clean page that is also forbidden. A wrong priority returns the other entry's page number, and a wrong result ordering reports an update request where a fault is due. Finally, it loads an entry in the same cycle as a lookup, holds responses under back-pressure, and mixes invalidate-all with a write. Getting any of these wrong shows up as a stale or early translation, a lost response, or an entry that survives the flush.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int PG_SH  = 12;
  localparam int MID_SH = 18;
  localparam int BIG_SH = 24;
  localparam int VTAG_W = VA_W - PG_SH;
  localparam int PPN_W  = PA_W - PG_SH;
  localparam int CTX_W  = 8;

  typedef struct packed {
    logic              valid;
    logic [VTAG_W-1:0] vtag;
    logic [1:0]        psize;
    logic [CTX_W-1:0]  ctx;
    logic [2:0]        acc;
    logic [PPN_W-1:0]  ppn;
    logic              cache;
    logic              mod;
  } tlbx_entry_t;

  typedef enum logic [1:0] {
    RES_OK     = 2'd0,
    RES_MISS   = 2'd1,
    RES_FAULT  = 2'd2,
    RES_MODIFY = 2'd3
  } tlbx_res_e;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_EXEC  = 2'd2,
    KIND_RSVD  = 2'd3
  } tlbx_kind_e;

  // Tag bits (address bits 31..12) that take part in the compare for a size code.
  function automatic logic [VTAG_W-1:0] page_mask(input logic [1:0] psize);
    logic [VTAG_W-1:0] m;
    case (psize)
      2'b00:   m = {VTAG_W{1'b1}};
      2'b01:   m = {VTAG_W{1'b1}} << (MID_SH - PG_SH);
      2'b10:   m = {VTAG_W{1'b1}} << (BIG_SH - PG_SH);
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/tlbx_store.sv
module tlbx_store
  import tlbx_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  tlbx_entry_t                   wr_entry,
  input  logic                          inv_all,
  output tlbx_entry_t [NUM_ENTRIES-1:0] table_q
);

  logic [NUM_ENTRIES-1:0] valid_vec;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_slot
    tlbx_entry_t slot_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else if (inv_all) begin
        slot_q.valid <= 1'b0;
      end else if (wr_en && (wr_idx == IDX_W'(g))) begin
        slot_q <= wr_entry;
      end
    end
    assign table_q[g]   = slot_q;
    assign valid_vec[g] = slot_q.valid;
  end

  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_vec == '0)); // R12

  AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all && (int'(wr_idx) < NUM_ENTRIES))
      |=> (table_q[$past(wr_idx)] == $past(wr_entry))); // R11

endmodule

// File: rtl/tlbx_match.sv
module tlbx_match
  import tlbx_pkg::*;
(
  input  logic              ent_valid,
  input  logic [VTAG_W-1:0] ent_vtag,
  input  logic [1:0]        ent_psize,
  input  logic [CTX_W-1:0]  ent_ctx,
  input  logic [1:0]        ent_acc_hi,
  input  logic [VTAG_W-1:0] va_tag,
  input  logic [CTX_W-1:0]  cur_ctx,
  output logic              hit
);

  logic [VTAG_W-1:0] diff;
  logic              tag_ok;
  logic              ctx_ok;

  always_comb begin
    diff   = (va_tag ^ ent_vtag) & page_mask(ent_psize);
    tag_ok = (diff == '0);
    // Supervisor-only codes (6 and 7) are shared across all contexts.
    ctx_ok = (ent_ctx == cur_ctx) || (ent_acc_hi == 2'b11);
    hit    = ent_valid && tag_ok && ctx_ok;
  end

endmodule

// File: rtl/tlbx_perm.sv
module tlbx_perm
  import tlbx_pkg::*;
(
  input  logic [2:0]  acc,
  input  tlbx_kind_e  kind,
  input  logic        is_priv,
  output logic        allowed
);

  logic may_rd, may_wr, may_ex;

  always_comb begin
    case (acc)
      3'd0:    {may_rd, may_wr, may_ex} = 3'b100;
      3'd1:    {may_rd, may_wr, may_ex} = 3'b110;
      3'd2:    {may_rd, may_wr, may_ex} = 3'b101;
      3'd3:    {may_rd, may_wr, may_ex} = 3'b111;
      3'd4:    {may_rd, may_wr, may_ex} = 3'b001;
      3'd5:    {may_rd, may_wr, may_ex} = is_priv ? 3'b110 : 3'b100;
      3'd6:    {may_rd, may_wr, may_ex} = is_priv ? 3'b101 : 3'b000;
      default: {may_rd, may_wr, may_ex} = is_priv ? 3'b111 : 3'b000;
    endcase
    case (kind)
      KIND_WRITE: allowed = may_wr;
      KIND_EXEC:  allowed = may_ex;
      default:    allowed = may_rd;
    endcase
  end

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int IDX_W       = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xlate_en,
  input  logic [CTX_W-1:0]  cur_ctx,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic              req_super,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_cacheable,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [VTAG_W-1:0] wr_vtag,
  input  logic [1:0]        wr_psize,
  input  logic [CTX_W-1:0]  wr_ctx,
  input  logic [2:0]        wr_acc,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_cacheable,
  input  logic              wr_modified,
  input  logic              inv_all
);

  localparam int PAD_W = PA_W - VA_W;

  tlbx_entry_t                   wr_entry;
  tlbx_entry_t [NUM_ENTRIES-1:0] tbl;
  logic [NUM_ENTRIES-1:0]        hit_vec;
  logic [NUM_ENTRIES-1:0]        win_vec;

  always_comb begin
    wr_entry.valid = wr_valid;
    wr_entry.vtag  = wr_vtag;
    wr_entry.psize = wr_psize;
    wr_entry.ctx   = wr_ctx;
    wr_entry.acc   = wr_acc;
    wr_entry.ppn   = wr_ppn;
    wr_entry.cache = wr_cacheable;
    wr_entry.mod   = wr_modified;
  end

  tlbx_store #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_entry (wr_entry),
    .inv_all  (inv_all),
    .table_q  (tbl)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    tlbx_match u_match (
      .ent_valid  (tbl[g].valid),
      .ent_vtag   (tbl[g].vtag),
      .ent_psize  (tbl[g].psize),
      .ent_ctx    (tbl[g].ctx),
      .ent_acc_hi (tbl[g].acc[2:1]),
      .va_tag     (req_vaddr[VA_W-1:PG_SH]),
      .cur_ctx    (cur_ctx),
      .hit        (hit_vec[g])
    );
  end

  // Lowest-index hit wins; only the fields needed downstream are selected.
  logic              any_hit;
  logic [2:0]        sel_acc;
  logic [1:0]        sel_psize;
  logic [PPN_W-1:0]  sel_ppn;
  logic              sel_cache;
  logic              sel_mod;

  always_comb begin
    win_vec   = '0;
    any_hit   = 1'b0;
    sel_acc   = '0;
    sel_psize = '0;
    sel_ppn   = '0;
    sel_cache = 1'b0;
    sel_mod   = 1'b0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (hit_vec[i] && !any_hit) begin
        win_vec[i] = 1'b1;
        any_hit    = 1'b1;
        sel_acc    = tbl[i].acc;
        sel_psize  = tbl[i].psize;
        sel_ppn    = tbl[i].ppn;
        sel_cache  = tbl[i].cache;
        sel_mod    = tbl[i].mod;
      end
    end
  end

  logic perm_ok;

  tlbx_perm u_perm (
    .acc     (sel_acc),
    .kind    (tlbx_kind_e'(req_kind)),
    .is_priv (req_super),
    .allowed (perm_ok)
  );

  logic [VA_W-1:0] off_mask;
  logic [PA_W-1:0] xl_paddr;
  logic            is_write;
  tlbx_res_e       nxt_code;
  logic [PA_W-1:0] nxt_paddr;
  logic            nxt_cache;

  always_comb begin
    off_mask = ~{page_mask(sel_psize), {PG_SH{1'b0}}};
    xl_paddr = ({sel_ppn, {PG_SH{1'b0}}} & ~{{PAD_W{1'b0}}, off_mask})
             | {{PAD_W{1'b0}}, req_vaddr & off_mask};
    is_write = (tlbx_kind_e'(req_kind) == KIND_WRITE);

    nxt_code  = RES_OK;
    nxt_paddr = '0;
    nxt_cache = 1'b0;
    if (!xlate_en) begin
      nxt_paddr = {{PAD_W{1'b0}}, req_vaddr};
    end else if (!any_hit) begin
      nxt_code = RES_MISS;
    end else if (!perm_ok) begin
      nxt_code = RES_FAULT;
    end else if (is_write && !sel_mod) begin
      nxt_code = RES_MODIFY;
    end else begin
      nxt_paddr = xl_paddr;
      nxt_cache = sel_cache;
    end
  end

  // One-deep response stage.
  logic      accept;
  tlbx_res_e code_q;

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign rsp_code  = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      code_q        <= RES_OK;
      rsp_paddr     <= '0;
      rsp_cacheable <= 1'b0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      code_q        <= nxt_code;
      rsp_paddr     <= nxt_paddr;
      rsp_cacheable <= nxt_cache;
    end else if (rsp_ready) begin
      rsp_valid     <= 1'b0;
    end
  end

  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec)); // R10

  AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid); // R2

  AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_code)
      && $stable(rsp_paddr) && $stable(rsp_cacheable))); // R2

  AST_BYPASS_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !xlate_en) |=> (rsp_code == RES_OK
      && rsp_paddr == {{PAD_W{1'b0}}, $past(req_vaddr)})); // R3

  AST_NO_HIT_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && xlate_en && (hit_vec == '0)) |=> (rsp_code == RES_MISS)); // R9

  AST_NONOK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != RES_OK) |-> (rsp_paddr == '0 && !rsp_cacheable)); // R9

  AST_USER_KEPT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && xlate_en && any_hit && !req_super && sel_acc[2:1] == 2'b11)
      |=> (rsp_code == RES_FAULT)); // R7

endmodule

// File: tb/tlbx_lookup_tb.sv
module tlbx_lookup_tb_top;
  import tlbx_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        rst_n, xlate_en, req_valid, req_ready, req_super;
  logic [7:0]  cur_ctx;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind, rsp_code, wr_idx, wr_psize;
  logic        rsp_valid, rsp_ready, rsp_cacheable;
  logic [35:0] rsp_paddr;
  logic        wr_en, wr_valid, wr_cacheable, wr_modified, inv_all;
  logic [19:0] wr_vtag;
  logic [7:0]  wr_ctx;
  logic [2:0]  wr_acc;
  logic [23:0] wr_ppn;

  tlbx_lookup #(.NUM_ENTRIES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .xlate_en(xlate_en), .cur_ctx(cur_ctx),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .req_super(req_super), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_paddr(rsp_paddr),
    .rsp_cacheable(rsp_cacheable), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_valid(wr_valid), .wr_vtag(wr_vtag), .wr_psize(wr_psize),
    .wr_ctx(wr_ctx), .wr_acc(wr_acc), .wr_ppn(wr_ppn),
    .wr_cacheable(wr_cacheable), .wr_modified(wr_modified), .inv_all(inv_all)
  );

  // Behavioural reference state
  bit          m_v   [N];
  logic [19:0] m_vtag[N];
  logic [1:0]  m_psz [N];
  logic [7:0]  m_ctx [N];
  logic [2:0]  m_acc [N];
  logic [23:0] m_ppn [N];
  bit          m_c   [N];
  bit          m_m   [N];
  bit          exp_valid;
  int          exp_code;
  logic [35:0] exp_pa;
  bit          exp_c;

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  // Rights as {exec, write, read}
  function automatic logic [2:0] rights(logic [2:0] acc, bit sup);
    case (acc)
      3'd0: return 3'b001;
      3'd1: return 3'b011;
      3'd2: return 3'b101;
      3'd3: return 3'b111;
      3'd4: return 3'b100;
      3'd5: return sup ? 3'b011 : 3'b001;
      3'd6: return sup ? 3'b101 : 3'b000;
      default: return sup ? 3'b111 : 3'b000;
    endcase
  endfunction

  function automatic void model_eval(output int code, output logic [35:0] pa, output bit c);
    int h, keep, hkeep, k;
    logic [2:0] r;
    logic [35:0] lowm;
    h = -1; hkeep = 12;
    code = 1; pa = '0; c = 1'b0;
    if (!xlate_en) begin
      code = 0; pa = {4'h0, req_vaddr};
      return;
    end
    for (int i = 0; i < N; i++) begin
      keep = (m_psz[i] == 2'd0) ? 12 : (m_psz[i] == 2'd1) ? 18 : (m_psz[i] == 2'd2) ? 24 : 32;
      if (h < 0 && m_v[i] && ((req_vaddr >> keep) == ({m_vtag[i], 12'h000} >> keep))
          && (m_ctx[i] == cur_ctx || m_acc[i] >= 3'd6)) begin
        h = i; hkeep = keep;
      end
    end
    if (h < 0) return;
    k = (req_kind == 2'd1) ? 1 : (req_kind == 2'd2) ? 2 : 0;
    r = rights(m_acc[h], req_super);
    if (!r[k]) code = 2;
    else if (k == 1 && !m_m[h]) code = 3;
    else begin
      code = 0;
      lowm = (36'h1 << hkeep) - 36'h1;
      pa = ({m_ppn[h], 12'h000} & ~lowm) | ({4'h0, req_vaddr} & lowm);
      c = m_c[h];
    end
  endfunction

  task automatic tick();
    int code;
    logic [35:0] pa;
    bit c, rdy, acc;
    #1;
    rdy = !exp_valid || rsp_ready;
    n_cmp++;
    if (req_ready !== rdy) begin
      n_bad++;
      $display("FAIL R2 (%s): req_ready=%0b expected %0b", tag, req_ready, rdy);
    end
    acc = req_valid && rdy;
    model_eval(code, pa, c);
    @(negedge clk);
    if (acc) begin
      exp_valid = 1'b1; exp_code = code; exp_pa = pa; exp_c = c;
    end else if (rsp_ready) begin
      exp_valid = 1'b0;
    end
    if (inv_all) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else if (wr_en) begin
      m_v[wr_idx] = wr_valid; m_vtag[wr_idx] = wr_vtag; m_psz[wr_idx] = wr_psize;
      m_ctx[wr_idx] = wr_ctx; m_acc[wr_idx] = wr_acc; m_ppn[wr_idx] = wr_ppn;
      m_c[wr_idx] = wr_cacheable; m_m[wr_idx] = wr_modified;
    end
    n_cmp++;
    if (rsp_valid !== exp_valid || (exp_valid && (rsp_code !== 2'(exp_code)
        || rsp_paddr !== exp_pa || rsp_cacheable !== exp_c))) begin
      n_bad++;
      $display("FAIL %s: valid=%0b code=%0d pa=%h c=%0b expected valid=%0b code=%0d pa=%h c=%0b",
               tag, rsp_valid, rsp_code, rsp_paddr, rsp_cacheable,
               exp_valid, exp_code, exp_pa, exp_c);
    end
  endtask

  task automatic put(int idx, bit v, logic [19:0] vt, logic [1:0] ps, logic [7:0] cx,
                     logic [2:0] ac, logic [23:0] pp, bit c, bit m);
    wr_en = 1'b1; wr_idx = 2'(idx); wr_valid = v; wr_vtag = vt; wr_psize = ps;
    wr_ctx = cx; wr_acc = ac; wr_ppn = pp; wr_cacheable = c; wr_modified = m;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [1:0] k, bit s);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_super = s;
    tick();
    req_valid = 1'b0;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; xlate_en = 1'b0; cur_ctx = 8'd5; req_valid = 1'b0; req_vaddr = '0;
    req_kind = '0; req_super = 1'b0; rsp_ready = 1'b1; wr_en = 1'b0; wr_idx = '0;
    wr_valid = 1'b0; wr_vtag = '0; wr_psize = '0; wr_ctx = '0; wr_acc = '0; wr_ppn = '0;
    wr_cacheable = 1'b0; wr_modified = 1'b0; inv_all = 1'b0;
    exp_valid = 1'b0; exp_code = 0; exp_pa = '0; exp_c = 1'b0;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_vtag[i] = '0; m_psz[i] = '0; m_ctx[i] = '0;
      m_acc[i] = '0; m_ppn[i] = '0; m_c[i] = 0; m_m[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, then an enabled lookup into an empty table misses
    tag = "R1";
    tick();
    xlate_en = 1'b1;
    look(32'h1234_5678, 2'd0, 1'b1);

    // R3: identity mapping when translation is off
    tag = "R3";
    xlate_en = 1'b0;
    look(32'hDEAD_BEEF, 2'd1, 1'b0);
    look(32'hFFFF_FFFF, 2'd2, 1'b1);
    xlate_en = 1'b1;

    // R5 / R4: hits and near misses for each page size
    tag = "R5";
    put(0, 1, 20'h12345, 2'd0, 8'd5, 3'd1, 24'hABCDEF, 1, 1);
    look(32'h1234_5678, 2'd0, 1'b0);
    tag = "R4";
    look(32'h1234_6000, 2'd0, 1'b0);
    put(1, 1, 20'h40000, 2'd1, 8'd5, 3'd3, 24'h111111, 0, 1);
    look(32'h4003_FFFC, 2'd2, 1'b0);
    look(32'h4004_0000, 2'd0, 1'b0);
    put(2, 1, 20'h80000, 2'd2, 8'd5, 3'd3, 24'h9AB000, 1, 1);
    look(32'h80FF_FFFF, 2'd1, 1'b1);
    look(32'h8100_0000, 2'd0, 1'b1);

    // R6 / R7: 4 GB supervisor-only entry in a foreign context
    tag = "R6";
    put(3, 1, 20'h00000, 2'd3, 8'd9, 3'd7, 24'hF00000, 1, 1);
    look(32'hC000_0123, 2'd1, 1'b1);
    tag = "R7";
    look(32'hC000_0123, 2'd0, 1'b0);
    put(3, 0, 20'h00000, 2'd3, 8'd9, 3'd7, 24'hF00000, 1, 1);
    tag = "R6";
    put(0, 1, 20'h12345, 2'd0, 8'd7, 3'd1, 24'hABCDEF, 1, 1);
    look(32'h1234_5000, 2'd0, 1'b1);
    put(0, 1, 20'h12345, 2'd0, 8'd7, 3'd6, 24'hABCDEF, 1, 1);
    look(32'h1234_5000, 2'd2, 1'b1);

    // R7: full permission table
    tag = "R7";
    for (int a = 0; a < 8; a++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < 4; k++) begin
          put(0, 1, 20'h12345, 2'd0, 8'd5, 3'(a), 24'h0C0FFE, 0, 1);
          look(32'h1234_5ABC, 2'(k), s[0]);
        end

    // R8: clean page writes
    tag = "R8";
    put(0, 1, 20'h12345, 2'd0, 8'd5, 3'd1, 24'h222222, 1, 0);
    look(32'h1234_5004, 2'd1, 1'b0);
    look(32'h1234_5004, 2'd0, 1'b0);
    put(0, 1, 20'h12345, 2'd0, 8'd5, 3'd0, 24'h222222, 1, 0);
    look(32'h1234_5004, 2'd1, 1'b1);

    // R9: miss outputs are quiet
    tag = "R9";
    look(32'h0000_1000, 2'd0, 1'b1);

    // R10: overlapping entries, lowest index wins
    tag = "R10";
    put(0, 1, 20'h12345, 2'd0, 8'd5, 3'd3, 24'h333333, 0, 1);
    put(1, 1, 20'h12340, 2'd1, 8'd5, 3'd3, 24'h444444, 1, 1);
    look(32'h1234_5678, 2'd0, 1'b0);
    put(0, 0, 20'h12345, 2'd0, 8'd5, 3'd3, 24'h333333, 0, 1);
    put(2, 1, 20'h12345, 2'd0, 8'd5, 3'd0, 24'h555555, 0, 1);
    look(32'h1234_5678, 2'd1, 1'b0);

    // R11: write and lookup in the same cycle
    tag = "R11";
    req_valid = 1'b1; req_vaddr = 32'h1234_5010; req_kind = 2'd0; req_super = 1'b0;
    put(1, 1, 20'h12345, 2'd0, 8'd5, 3'd3, 24'h666666, 0, 1);
    req_valid = 1'b0;
    tick();
    look(32'h1234_5010, 2'd0, 1'b0);

    // R12: flush, and flush together with a write
    tag = "R12";
    inv_all = 1'b1; tick(); inv_all = 1'b0;
    look(32'h1234_5010, 2'd0, 1'b1);
    inv_all = 1'b1;
    put(0, 1, 20'h12345, 2'd0, 8'd5, 3'd3, 24'h777777, 0, 1);
    inv_all = 1'b0;
    look(32'h1234_5010, 2'd0, 1'b1);

    // R2: back-pressure with requests waiting
    tag = "R2";
    put(0, 1, 20'h12345, 2'd0, 8'd5, 3'd3, 24'h888888, 1, 1);
    rsp_ready = 1'b0;
    req_valid = 1'b1; req_vaddr = 32'h1234_5100; req_kind = 2'd0; req_super = 1'b0;
    tick();
    req_vaddr = 32'h5555_0000;
    tick(); tick(); tick();
    rsp_ready = 1'b1;
    tick(); tick();
    req_valid = 1'b0;
    tick(); tick();

    // R2 / R7 mixed traffic
    tag = "R2 mixed";
    put(0, 1, 20'h12345, 2'd0, 8'd5, 3'd5, 24'h010101, 1, 0);
    put(1, 1, 20'h40000, 2'd1, 8'd7, 3'd2, 24'h020202, 0, 1);
    put(2, 1, 20'h80000, 2'd2, 8'd5, 3'd6, 24'h030303, 1, 1);
    put(3, 1, 20'hC0000, 2'd3, 8'd5, 3'd1, 24'h040404, 1, 0);
    for (int t = 0; t < 600; t++) begin
      int idx;
      idx = int'($urandom % N);
      req_valid = ($urandom % 3) != 0;
      rsp_ready = ($urandom % 4) != 0;
      req_vaddr = {m_vtag[idx], 12'($urandom)} ^ (($urandom % 4 == 0) ? 32'($urandom) : 32'h0);
      req_kind  = 2'($urandom);
      req_super = 1'($urandom);
      cur_ctx   = ($urandom % 2 == 0) ? 8'd5 : 8'd7;
      xlate_en  = ($urandom % 8) != 0;
      wr_en     = ($urandom % 16) == 0;
      inv_all   = ($urandom % 64) == 0;
      wr_idx = 2'($urandom); wr_valid = 1'b1; wr_vtag = 20'($urandom);
      wr_psize = 2'($urandom); wr_ctx = ($urandom % 2 == 0) ? 8'd5 : 8'd7;
      wr_acc = 3'($urandom); wr_ppn = 24'($urandom);
      wr_cacheable = 1'($urandom); wr_modified = 1'($urandom);
      tick();
    end
    wr_en = 1'b0; inv_all = 1'b0; req_valid = 1'b0; rsp_ready = 1'b1;
    tick(); tick();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule